// File: doc/BRIEF.md
# Narrow-Operand Gated Integer Unit

This block is a single-cycle 64-bit integer execution stage that saves switching power on small values. Each operand is captured in two registers: one for the low 16 bits and one for the upper 48 bits. A detector checks the incoming operands before they are registered. When both upper words are zero and the result cannot spill past bit 15, the upper registers keep their old contents. Only the 16-bit slice then matters, and the upper 48 result bits are replaced by zeros. A register load enable does this job, so the design needs no clock-gating cell.

The unit does addition and three bitwise operations. The result appears one cycle after the operands are accepted. A free-running counter records how many accepted operations ran on the narrow path. This lets the saving be measured, and it lets the gating decision be seen from outside the block.

Top module: `narrow_gated_alu`

## Requirements
- R1: While `rstN` is low, and right after it is released, `outValid` is 0, `outResult` is 0 and `gateCount` is 0. Reset is asynchronous and active low.
- R2: An operation accepted with `inValid` high at clock edge k shows up after edge k with `outValid` high and `outResult` equal to the full 64-bit result, reduced modulo 2^64. `inOp` is encoded as 00 add, 01 and, 10 or, 11 xor.
- R3: An operation takes the narrow path when both of these hold: bits 63..16 of both operands are zero, and the operation is not an add whose low 16-bit sum carries out. On the narrow path, `outResult[63:16]` is zero even when the upper registers still hold an earlier wide operand. `outResult[15:0]` is the correct result.
- R4: An add of two operands whose upper 48 bits are zero takes the full-width path when the sum of their low 16 bits is 0x10000 or more. `outResult[16]` is then 1.
- R5: `gateCount` goes up by exactly one for each accepted narrow-path operation, in the cycle its result appears. During such an operation the upper operand registers are not loaded.
- R6: A cycle with `inValid` low is ignored. After it, `outValid` is 0, `outResult` is 0 and `gateCount` is unchanged.
- R7: When exactly one operand has a nonzero upper word, the operation takes the full-width path. The result is correct and `gateCount` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| inOp | input | 2 | Operation code: 00 add, 01 and, 10 or, 11 xor |
| inA | input | 64 | First operand |
| inB | input | 64 | Second operand |
| outValid | output | 1 | Result valid, one cycle after acceptance |
| outResult | output | 64 | Result; zero when not valid |
| gateCount | output | 16 | Number of operations that ran with the upper half gated |

## Verification
The bench first looks for an add on two small operands that carries out of bit 15. A design that gates this case would return 0x0000 in place of 0x10000. It then issues a narrow operation right after a wide one. A design that takes the upper bits from the stale upper registers, rather than forcing them to zero, would leak the earlier operand into the result. It also mixes one wide operand with one narrow operand, and inserts idle cycles that carry narrow-looking operands. Against `gateCount`, a detector that tests only one operand, or that counts invalid cycles, would report a count that drifts from the expected one.

// File: rtl/ngalu_pkg.sv
package ngalu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_AND = 2'b01,
    OP_OR  = 2'b10,
    OP_XOR = 2'b11
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLo;     // capture low operand slices and opcode
    logic loadHi;     // capture upper operand slices
    logic narrowNow;  // operation being accepted uses the narrow path
    logic narrowQ;    // registered narrow decision for the held operation
    logic validQ;     // registered valid for the held operation
  } ctrlStrobe_t;

endpackage

// File: rtl/ngalu_ctrl.sv
module ngalu_ctrl
  import ngalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LO_W   = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output ctrlStrobe_t       strobe,
  output logic [CNT_W-1:0]  gateCount
);

  localparam int HI_W = DATA_W - LO_W;

  logic          aUpperZero;
  logic          bUpperZero;
  logic [LO_W:0] loSumExt;
  logic          loCarry;
  logic          isAdd;
  logic          takeNarrow;
  logic          narrowQ;
  logic          validQ;

  // Zero detectors on the upper words
  assign aUpperZero = (inA[DATA_W-1:LO_W] == HI_W'(0));
  assign bUpperZero = (inB[DATA_W-1:LO_W] == HI_W'(0));

  // An add could spill into bit LO_W; detect that early
  assign loSumExt   = {1'b0, inA[LO_W-1:0]} + {1'b0, inB[LO_W-1:0]};
  assign loCarry    = loSumExt[LO_W];
  assign isAdd      = (inOp == 2'(OP_ADD));

  assign takeNarrow = inValid & aUpperZero & bUpperZero & ~(isAdd & loCarry);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      narrowQ   <= 1'b0;
      validQ    <= 1'b0;
      gateCount <= '0;
    end else begin
      narrowQ <= takeNarrow;
      validQ  <= inValid;
      if (takeNarrow) gateCount <= gateCount + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.loadLo    = inValid;
    strobe.loadHi    = inValid & ~takeNarrow;
    strobe.narrowNow = takeNarrow;
    strobe.narrowQ   = narrowQ;
    strobe.validQ    = validQ;
  end

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> $stable(gateCount)); // R6

  AST_WIDE_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !(aUpperZero && bUpperZero)) |-> $stable(gateCount)); // R7

endmodule

// File: rtl/ngalu_dp.sv
module ngalu_dp
  import ngalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  ctrlStrobe_t       strobe,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);

  localparam int HI_W  = DATA_W - LO_W;
  localparam int LANES = 2;

  logic [LANES-1:0][DATA_W-1:0] opIn;
  logic [LANES-1:0][LO_W-1:0]   loVal;
  logic [LANES-1:0][HI_W-1:0]   hiVal;
  aluOp_e                       opQ;

  assign opIn[0] = inA;
  assign opIn[1] = inB;

  // Split operand registers, one pair per lane
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LO_W-1:0] loQ;
    logic [HI_W-1:0] hiQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              loQ <= '0;
      else if (strobe.loadLo) loQ <= opIn[ln][LO_W-1:0];
    end

    // Load enable stands in for a gated clock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              hiQ <= '0;
      else if (strobe.loadHi) hiQ <= opIn[ln][DATA_W-1:LO_W];
    end

    assign loVal[ln] = loQ;
    assign hiVal[ln] = hiQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              opQ <= OP_ADD;
    else if (strobe.loadLo) opQ <= aluOp_e'(inOp);
  end

  // Low slice and upper slice, chained by the add carry
  logic [LO_W:0]   loAddExt;
  logic [HI_W-1:0] hiAdd;
  logic [LO_W-1:0] loRes;
  logic [HI_W-1:0] hiRes;
  logic [DATA_W-1:0] selRes;

  assign loAddExt = {1'b0, loVal[0]} + {1'b0, loVal[1]};
  assign hiAdd    = hiVal[0] + hiVal[1] + HI_W'(loAddExt[LO_W]);

  always_comb begin
    unique case (opQ)
      OP_ADD: begin loRes = loAddExt[LO_W-1:0];  hiRes = hiAdd;                end
      OP_AND: begin loRes = loVal[0] & loVal[1]; hiRes = hiVal[0] & hiVal[1]; end
      OP_OR:  begin loRes = loVal[0] | loVal[1]; hiRes = hiVal[0] | hiVal[1]; end
      default: begin loRes = loVal[0] ^ loVal[1]; hiRes = hiVal[0] ^ hiVal[1]; end
    endcase
  end

  // Zero-select multiplexer on the upper result bits
  assign selRes    = strobe.narrowQ ? {HI_W'(0), loRes} : {hiRes, loRes};
  assign outResult = strobe.validQ ? selRes : '0;
  assign outValid  = strobe.validQ;

  // Checker-side view of the incoming low-slice carry
  logic [LO_W:0] chkLoSum;
  logic          chkBothSmall;
  assign chkLoSum     = {1'b0, inA[LO_W-1:0]} + {1'b0, inB[LO_W-1:0]};
  assign chkBothSmall = (inA[DATA_W-1:LO_W] == HI_W'(0)) && (inB[DATA_W-1:LO_W] == HI_W'(0));

  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.narrowNow |=> ($stable(hiVal[0]) && $stable(hiVal[1]))); // R5

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inOp != 2'(OP_ADD) && chkBothSmall) |-> (outResult[DATA_W-1:LO_W] == HI_W'(0))); // R3

  AST_CARRY_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inOp == 2'(OP_ADD) && chkBothSmall && chkLoSum[LO_W]) |-> outResult[LO_W]); // R4

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid)); // R2

endmodule

// File: rtl/narrow_gated_alu.sv
module narrow_gated_alu
  import ngalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LO_W   = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic [CNT_W-1:0]  gateCount
);

  ctrlStrobe_t strobe;

  ngalu_ctrl #(.DATA_W(DATA_W), .LO_W(LO_W), .CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inOp      (inOp),
    .inA       (inA),
    .inB       (inB),
    .strobe    (strobe),
    .gateCount (gateCount)
  );

  ngalu_dp #(.DATA_W(DATA_W), .LO_W(LO_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inOp      (inOp),
    .inA       (inA),
    .inB       (inB),
    .strobe    (strobe),
    .outValid  (outValid),
    .outResult (outResult)
  );

endmodule

// File: tb/test_narrow_gated_alu.sv
`timescale 1ns/1ps
module test_narrow_gated_alu;

  localparam int NVEC = 12;

  // {op, a, b}; op: 00 add, 01 and, 10 or, 11 xor
  localparam logic [129:0] VEC [NVEC] = '{
    {2'b00, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007},
    {2'b00, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001},
    {2'b01, 64'hDEAD_BEEF_0000_FFFF, 64'hFFFF_0000_FFFF_00F0},
    {2'b10, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0F00},
    {2'b11, 64'hFFFF_0000_1234_5678, 64'h0F0F_0F0F_0F0F_0F0F},
    {2'b00, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'b11, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_00FF},
    {2'b00, 64'h0000_0000_0000_0003, 64'h0000_0001_0000_0000},
    {2'b01, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_1234},
    {2'b00, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF},
    {2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'b10, 64'h0000_0000_0000_0001, 64'hFFFF_0000_0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'b00;
  logic [63:0] inA = '0;
  logic [63:0] inB = '0;
  logic        outValid;
  logic [63:0] outResult;
  logic [15:0] gateCount;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  narrow_gated_alu i_narrow_gated_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .inA(inA), .inB(inB), .outValid(outValid), .outResult(outResult),
    .gateCount(gateCount)
  );

  function automatic logic [63:0] refAlu(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a & b;
      2'b10:   return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic bit expNarrow(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [16:0] s;
    s = {1'b0, a[15:0]} + {1'b0, b[15:0]};
    return (a[63:16] == 0) && (b[63:16] == 0) && !(op == 2'b00 && s[16]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #80000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] expCount;
    expCount = '0;

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 valid in reset", 64'(outValid), 64'd0);
    chk(outResult == '0, "R1 result in reset", outResult, 64'd0);
    chk(gateCount == '0, "R1 count in reset", 64'(gateCount), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && outResult == '0, "R1 idle after release", outResult, 64'd0);

    // Vector table, one operation per cycle
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op;
      logic [63:0] a, b, exp;
      bit          nar;
      string       tag;
      {op, a, b} = VEC[i];
      inValid = 1'b1; inOp = op; inA = a; inB = b;
      exp = refAlu(op, a, b);
      nar = expNarrow(op, a, b);
      if (nar) expCount++;
      if (nar)                                  tag = "R3 narrow path";
      else if (a[63:16] == 0 && b[63:16] == 0)  tag = "R4 carry forces full";
      else if (a[63:16] == 0 || b[63:16] == 0)  tag = "R7 mixed width";
      else                                      tag = "R2 full width";
      @(negedge clk);
      chk(outValid == 1'b1, "R2 valid latency", 64'(outValid), 64'd1);
      chk(outResult == exp, tag, outResult, exp);
      chk(gateCount == expCount, "R5 gated count", 64'(gateCount), 64'(expCount));
    end

    // R6: idle cycle with narrow-looking operands is ignored
    inValid = 1'b0; inOp = 2'b00; inA = 64'h12; inB = 64'h34;
    @(negedge clk);
    chk(outValid == 1'b0, "R6 idle valid", 64'(outValid), 64'd0);
    chk(outResult == '0, "R6 idle result", outResult, 64'd0);
    chk(gateCount == expCount, "R6 idle count", 64'(gateCount), 64'(expCount));

    // R4: carry edge exactly at 0x10000, then R3 just below it
    inValid = 1'b1; inOp = 2'b00; inA = 64'hFFFE; inB = 64'h0002;
    @(negedge clk);
    chk(outResult == 64'h1_0000, "R4 carry to bit 16", outResult, 64'h1_0000);
    chk(gateCount == expCount, "R4 count unchanged", 64'(gateCount), 64'(expCount));
    inA = 64'hFFFE; inB = 64'h0001;
    expCount++;
    @(negedge clk);
    chk(outResult == 64'hFFFF, "R3 largest narrow sum", outResult, 64'hFFFF);
    chk(gateCount == expCount, "R5 count step", 64'(gateCount), 64'(expCount));

    // R1: asynchronous reset mid-run clears count and output
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(gateCount == '0, "R1 async reset count", 64'(gateCount), 64'd0);
    chk(outValid == 1'b0, "R1 async reset valid", 64'(outValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule